// File: doc/BRIEF.md
# Microcode Address Latch with Extended-Page Flag

This block captures the instruction byte for a microcoded processor and produces the address that indexes its microcode store. It holds an 8-bit opcode, a one-bit page flag that selects a second opcode page, and a 3-bit micro-step count. The control sequencer drives its strobes: one loads the opcode from the data bus, one marks the current byte as a prefix for the extended page, and one ends the instruction by restarting the step count.

The opcode loads on the rising clock edge. The step count and the page flag change on the falling edge, half a cycle away from the loads. The microcode outputs therefore settle before the next rising edge consumes them. Every restart of the step count clears the page flag, so a prefix affects only the instruction that follows it. A restart comes from the end strobe, from passing the eighth step, or from a system clear. A hold counter stretches the external clear for a set number of cycles after it is released. This stands in for a power-on delay.

Top module: `uc_instr_reg`

## Requirements
- R1: While `rst_n` is low on a rising edge, `opcode` becomes 0 at that edge, and `step` and `ext_page` become 0 at the next falling edge.
- R2: On a rising edge with `ir_load` high and no clear active, `opcode` takes `bus_data`. With `ir_load` low, `opcode` keeps its value whatever `bus_data` does.
- R3: On a falling edge with no clear active, `step_clr` low and `step` below 7, `step` rises by exactly one.
- R4: On a falling edge with `step_clr` high, `step` becomes 0 and `ext_page` becomes 0.
- R5: On a falling edge with `step` equal to 7, `step` wraps to 0 and `ext_page` becomes 0, exactly as for `step_clr`.
- R6: On a falling edge with `ext_set` high and no restart condition, `ext_page` becomes 1. It then stays 1 across later opcode loads until the next restart.
- R7: After `rst_n` returns high, the clear stays in force for `POR_CYCLES` further rising edges. During that time `opcode`, `step` and `ext_page` stay 0, and loads are ignored.
- R8: `ucode_addr` is `{ext_page, opcode, step}`: bit 11 is the page flag, bits 10..3 are the opcode, and bits 2..0 are the step.
- R9: Priority is clear first, then restart (`step_clr` or overflow), then `ext_set`. When `ext_set` and `step_clr` are high on the same falling edge, `ext_page` ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; loads on rising edge, steps on falling edge |
| rst_n | input | 1 | Synchronous active-low system clear |
| bus_data | input | 8 | Data bus carrying the instruction byte |
| ir_load | input | 1 | Load opcode from `bus_data` |
| ext_set | input | 1 | Set the extended-page flag |
| step_clr | input | 1 | End of instruction: restart step count, clear page flag |
| opcode | output | 8 | Current opcode |
| ext_page | output | 1 | Extended-page flag |
| step | output | 3 | Current micro-step |
| ucode_addr | output | 12 | Combined microcode store address |

## Verification
The properties assume that the strobes are stable between a falling edge and the following rising edge. This holds when they come from microcode words indexed by the step count. The properties are also evaluated only when no clear is in force. The bench drives every input just after a falling edge. It holds them for a full period, so both edges of the register see the same values. The sequences the bench drives are ordinary fetch patterns: an opcode load at step 0, a prefix followed by a second load, a run past the last step, and a clear dropped in mid-instruction.

// File: rtl/ir_pkg.sv
// Shared defaults and types for the microcode address latch.
// Assumes: consumers import this package before use.
package ir_pkg;
    localparam int unsigned OP_W_DEF       = 8;
    localparam int unsigned STEP_W_DEF     = 3;
    localparam int unsigned POR_CYCLES_DEF = 4_000_000;

    // Action chosen by the step sequencer on each falling edge.
    typedef enum logic [1:0] {
        SEQ_CLEAR   = 2'd0,
        SEQ_RESTART = 2'd1,
        SEQ_ADVANCE = 2'd2
    } seq_action_e;
endpackage

// File: rtl/ir_power_hold.sv
// Stretches the external clear: the clear stays in force until POR_CYCLES
// rising edges have passed with rst_n high. POR_CYCLES of zero removes the
// counter. Assumes rst_n is synchronous to clk.
module ir_power_hold #(
    parameter int unsigned POR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic clr_active
);
    generate
        if (POR_CYCLES == 0) begin : g_no_hold
            // Purpose: clear follows the external input directly.
            assign clr_active = !rst_n;
        end else begin : g_hold
            localparam int unsigned CW = $clog2(POR_CYCLES + 1);
            localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);
            logic [CW-1:0] hold_cnt;

            // Purpose: count released cycles up to the limit, restart on clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_cnt <= '0;
                end else if (hold_cnt != LIMIT) begin
                    hold_cnt <= hold_cnt + CW'(1);
                end
            end

            // Purpose: clear in force while held low or still counting.
            assign clr_active = !rst_n || (hold_cnt != LIMIT);

            AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                hold_cnt <= LIMIT);  // R7
            AST_HOLD_CLIMB: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_cnt != LIMIT) |=> (hold_cnt == $past(hold_cnt) + CW'(1)));  // R7
        end
    endgenerate
endmodule

// File: rtl/ir_opcode_reg.sv
// Opcode holding register, loaded from the data bus on the rising edge.
// Assumes clr_active is synchronous to the rising edge.
module ir_opcode_reg #(
    parameter int unsigned OP_W = 8
) (
    input  logic            clk,
    input  logic            clr_active,
    input  logic            ir_load,
    input  logic [OP_W-1:0] bus_data,
    output logic [OP_W-1:0] opcode
);
    // Purpose: clear, load or hold the opcode.
    always_ff @(posedge clk) begin
        if (clr_active) begin
            opcode <= '0;
        end else if (ir_load) begin
            opcode <= bus_data;
        end
    end

    AST_OP_LOAD: assert property (@(posedge clk) disable iff (clr_active)
        ir_load |=> (opcode == $past(bus_data)));  // R2
    AST_OP_HOLD: assert property (@(posedge clk) disable iff (clr_active)
        !ir_load |=> $stable(opcode));  // R2
endmodule

// File: rtl/ir_step_seq.sv
// Micro-step counter and extended-page flag, both clocked on the falling
// edge. Any restart (clear, end strobe or passing the last step) zeroes
// the count and drops the page flag. Assumes strobes are stable across
// the falling edge.
module ir_step_seq
    import ir_pkg::*;
#(
    parameter int unsigned STEP_W = 3
) (
    input  logic              clk,
    input  logic              clr_active,
    input  logic              step_clr,
    input  logic              ext_set,
    output logic [STEP_W-1:0] step,
    output logic              ext_page
);
    localparam logic [STEP_W-1:0] LAST_STEP = '1;

    seq_action_e action;

    // Purpose: choose the action by priority: clear, restart, advance.
    always_comb begin
        if (clr_active) begin
            action = SEQ_CLEAR;
        end else if (step_clr || (step == LAST_STEP)) begin
            action = SEQ_RESTART;
        end else begin
            action = SEQ_ADVANCE;
        end
    end

    // Purpose: update count and page flag on the falling edge.
    always_ff @(negedge clk) begin
        case (action)
            SEQ_ADVANCE: begin
                step <= step + STEP_W'(1);
                if (ext_set) begin
                    ext_page <= 1'b1;
                end
            end
            default: begin
                step     <= '0;
                ext_page <= 1'b0;
            end
        endcase
    end

    AST_STEP_ADV: assert property (@(negedge clk) disable iff (clr_active)
        (!step_clr && step != LAST_STEP) |=> (step == $past(step) + STEP_W'(1)));  // R3
    AST_STEP_CLR: assert property (@(negedge clk) disable iff (clr_active)
        step_clr |=> (step == '0 && !ext_page));  // R4
    AST_NO_OVERFLOW: assert property (@(negedge clk) disable iff (clr_active)
        (step == LAST_STEP) |=> (step == '0 && !ext_page));  // R5
    AST_EXT_SET: assert property (@(negedge clk) disable iff (clr_active)
        (ext_set && !step_clr && step != LAST_STEP) |=> ext_page);  // R6
    AST_EXT_KEEP: assert property (@(negedge clk) disable iff (clr_active)
        (ext_page && !step_clr && step != LAST_STEP) |=> ext_page);  // R6
endmodule

// File: rtl/uc_instr_reg.sv
// Top of the microcode address latch: opcode register, falling-edge step
// sequencer with extended-page flag, and a clear-stretching hold counter.
// Assumes all strobes come from logic timed by the falling edge.
module uc_instr_reg
    import ir_pkg::*;
#(
    parameter int unsigned OP_W       = OP_W_DEF,
    parameter int unsigned STEP_W     = STEP_W_DEF,
    parameter int unsigned POR_CYCLES = POR_CYCLES_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OP_W-1:0]        bus_data,
    input  logic                   ir_load,
    input  logic                   ext_set,
    input  logic                   step_clr,
    output logic [OP_W-1:0]        opcode,
    output logic                   ext_page,
    output logic [STEP_W-1:0]      step,
    output logic [OP_W+STEP_W:0]   ucode_addr
);
    logic clr_active;

    ir_power_hold #(.POR_CYCLES(POR_CYCLES)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_active (clr_active)
    );

    ir_opcode_reg #(.OP_W(OP_W)) op_i (
        .clk        (clk),
        .clr_active (clr_active),
        .ir_load    (ir_load),
        .bus_data   (bus_data),
        .opcode     (opcode)
    );

    ir_step_seq #(.STEP_W(STEP_W)) seq_i (
        .clk        (clk),
        .clr_active (clr_active),
        .step_clr   (step_clr),
        .ext_set    (ext_set),
        .step       (step),
        .ext_page   (ext_page)
    );

    // Purpose: pack the page flag, opcode and step into the store address.
    assign ucode_addr = {ext_page, opcode, step};

    AST_CLR_OPCODE: assert property (@(posedge clk)
        !rst_n |=> (opcode == '0));  // R1
endmodule

// File: tb/uc_instr_reg_tb_top.sv
`timescale 1ns/100ps
module uc_instr_reg_tb_top;
    localparam int unsigned P = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = 8'h00;
    logic        ir_load = 1'b0;
    logic        ext_set = 1'b0;
    logic        step_clr = 1'b0;
    logic [7:0]  opcode;
    logic        ext_page;
    logic [2:0]  step;
    logic [11:0] ucode_addr;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic [7:0] op;
        logic [2:0] st;
        logic       ex;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    // Reference state, from the requirements.
    logic [7:0] m_op = 8'h00;
    logic [2:0] m_st = 3'd0;
    logic       m_ex = 1'b0;
    int         m_cnt = 0;

    uc_instr_reg #(.POR_CYCLES(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .ir_load(ir_load),
        .ext_set(ext_set), .step_clr(step_clr), .opcode(opcode),
        .ext_page(ext_page), .step(step), .ucode_addr(ucode_addr)
    );

    always #2 clk = ~clk;

    // Driver: one cycle of stimulus, push the state expected after the next falling edge.
    task automatic cyc(input logic r, input logic ld, input logic [7:0] d,
                       input logic x, input logic sc, input string req);
        exp_t e;
        logic clr;
        @(negedge clk);
        #0.5;
        rst_n = r; ir_load = ld; bus_data = d; ext_set = x; step_clr = sc;
        clr = !r || (m_cnt != P);
        if (clr) m_op = 8'h00; else if (ld) m_op = d;
        if (!r) m_cnt = 0; else if (m_cnt != P) m_cnt++;
        clr = !r || (m_cnt != P);
        if (clr || sc || m_st == 3'd7) begin
            m_st = 3'd0; m_ex = 1'b0;
        end else begin
            m_st = m_st + 3'd1;
            if (x) m_ex = 1'b1;
        end
        e.op = m_op; e.st = m_st; e.ex = m_ex; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #0.2;
            if (sb_q.size() > 0) begin
                exp_t e;
                bit bad;
                e = sb_q.pop_front();
                bad = 0;
                compared++;
                if (opcode !== e.op) begin
                    $display("FAIL %s opcode: actual %h expected %h", e.req, opcode, e.op); bad = 1;
                end
                if (step !== e.st) begin
                    $display("FAIL %s step: actual %0d expected %0d", e.req, step, e.st); bad = 1;
                end
                if (ext_page !== e.ex) begin
                    $display("FAIL %s ext_page: actual %b expected %b", e.req, ext_page, e.ex); bad = 1;
                end
                if (ucode_addr !== {e.ex, e.op, e.st}) begin
                    $display("FAIL R8 ucode_addr: actual %h expected %h", ucode_addr, {e.ex, e.op, e.st}); bad = 1;
                end
                if (bad) mismatched++;
            end
        end
    end

    initial begin
        #(200000 * 4);
        $display("FAIL watchdog: actual timeout expected completion");
        mismatched++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'hA5, 1, 0, "R1");
        // R7: hold after release, loads ignored
        for (int i = 0; i < P + 1; i++) cyc(1, 1, 8'hAA, 1, 0, "R7");
        // Align to step 0 with a restart
        cyc(1, 0, 8'h00, 0, 1, "R4");
        // Normal instruction: load, run, end
        cyc(1, 1, 8'h59, 0, 0, "R2");
        cyc(1, 0, 8'hFF, 0, 0, "R2");
        cyc(1, 0, 8'h12, 0, 0, "R3");
        cyc(1, 0, 8'h00, 0, 1, "R4");
        // Extended sequence: prefix, set page, load second byte, run, end
        cyc(1, 1, 8'h3C, 0, 0, "R2");
        cyc(1, 0, 8'h00, 1, 0, "R6");
        cyc(1, 1, 8'h5A, 0, 0, "R6");
        cyc(1, 0, 8'h77, 0, 0, "R6");
        cyc(1, 0, 8'h00, 0, 1, "R4");
        // Overflow: run past step 7 with the page flag set
        cyc(1, 1, 8'hC3, 0, 0, "R3");
        cyc(1, 0, 8'h00, 1, 0, "R6");
        for (int i = 0; i < 8; i++) cyc(1, 0, 8'h00, 0, 0, "R5");
        // Simultaneous end and page-set: restart wins
        cyc(1, 0, 8'h00, 1, 0, "R6");
        cyc(1, 0, 8'h00, 1, 1, "R9");
        // Clear in the middle of an extended instruction
        cyc(1, 1, 8'h81, 1, 0, "R6");
        cyc(1, 0, 8'h00, 0, 0, "R3");
        cyc(0, 1, 8'h99, 1, 0, "R1");
        for (int i = 0; i < P + 1; i++) cyc(1, 1, 8'h44, 1, 0, "R7");
        cyc(1, 1, 8'h66, 0, 0, "R2");
        cyc(1, 0, 8'h00, 0, 0, "R3");
        @(negedge clk);
        @(negedge clk);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule